// File: doc/BRIEF.md
# Low-Power Wake-Up Sequencer

This block decides when a device leaves its two low-power modes and how it leaves them. Software first loads a small configuration word. The word holds a wake enable for each of four switch inputs, enables for two high-side sense drivers, a cyclic-sense or timed-wake mode choice, and a period select. Software then requests Stop or Sleep. While the device is in a low-power mode, the block watches several wake sources: the switch inputs, a qualified bus wake pulse, a shared period timer, a chip-select rising edge and a deglitched reset-pin request.

The two modes exit differently. A Stop exit raises a one-cycle interrupt. A Sleep exit raises a one-cycle request that turns the regulator on and resets the processor. Switch, bus and timer wakes are recorded in a status word so that software can find the cause afterwards. Chip-select and reset-pin wakes are silent: they set no status bit and raise no interrupt. The period timer counts ticks of a slow low-power clock. In cyclic-sense mode it pulses the selected sense drivers and compares the switches once per period. In timed mode it forces a wake when the period expires.

Top module: `lp_wake_seq`

## Requirements
- R1: After reset `mode_o` is 0 (Normal), and `cfg_rdata_o`, `wake_stat_o`, `irq_o`, `reg_on_rst_o` and `hs_en_o` are all zero. The mode encoding is 0 Normal, 1 Normal-Request, 2 Stop, 3 Sleep.
- R2: The configuration word is laid out as follows: bits [3:0] are the switch wake enables (bit i for switch i), [5:4] the sense-driver enables, [6] cyclic-sense mode, [7] timed-wake mode and [9:8] the period select. In modes 0 and 1, a write with `cfg_we_i` high is stored and read back on `cfg_rdata_o` on the next cycle.
- R3: A write is rejected whole, and the previous word is kept, if it sets both bit 6 and bit 7, or if it sets bit 7 while either sense-driver enable is set.
- R4: Configuration writes made in Stop or Sleep have no effect.
- R5: `enter_stop_i` or `enter_sleep_i`, seen in mode 0 or 1, moves the block to Stop or Sleep on the next cycle. Sleep wins if both are high. Entry clears `wake_stat_o` and samples the switch levels as the reference for change detection.
- R6: When cyclic-sense mode is off, a switch whose enable is set and whose level differs from its reference causes a wake. Status bit i is set for each such switch.
- R7: A switch selected on the analog multiplexer (`amux_en_i` high, `amux_sel_i` = its index) at the time of entry cannot wake the device.
- R8: A `lin_wake_i` pulse in Stop or Sleep causes a wake and sets status bit 4.
- R9: A reported wake in Stop returns the block to mode 0 and pulses `irq_o` high for exactly one cycle, in the same cycle as the mode change.
- R10: Any wake in Sleep returns the block to mode 0 and pulses `reg_on_rst_o` for one cycle. `irq_o` stays low.
- R11: In timed mode a wake occurs on the N-th low-power tick after entry and sets status bit 5. N is 4, 8, 16 or 32 for period select 0, 1, 2 or 3.
- R12: In cyclic-sense mode `hs_en_o` equals the configured driver enables during the last tick interval of each period and is zero otherwise. Enabled switches are compared only on the tick that ends the period. A period with no change does not wake the device.
- R13: In Stop, a rising edge on `cs_i` returns the block to mode 0 with no interrupt and no status bit set. In Sleep the edge is ignored.
- R14: In Stop, `rst_pin_i` high causes a silent wake into mode 1 if `nreq_sel_i` is 1, or into mode 0 if it is 0. In Sleep it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 10 | Configuration write data |
| cfg_rdata_o | output | 10 | Current configuration word |
| enter_stop_i | input | 1 | Request Stop mode |
| enter_sleep_i | input | 1 | Request Sleep mode |
| nreq_sel_i | input | 1 | Configuration pin: reset-pin wake goes to Normal-Request |
| lp_tick_i | input | 1 | One-cycle tick of the slow low-power clock |
| sw_i | input | 4 | Switch input levels |
| amux_en_i | input | 1 | Analog multiplexer selection valid |
| amux_sel_i | input | 2 | Switch index selected on the multiplexer |
| cs_i | input | 1 | Chip-select level |
| lin_wake_i | input | 1 | Qualified bus wake pulse |
| rst_pin_i | input | 1 | Deglitched reset-pin low request |
| mode_o | output | 2 | Current mode |
| irq_o | output | 1 | Stop-exit interrupt pulse |
| reg_on_rst_o | output | 1 | Sleep-exit regulator-on and reset pulse |
| hs_en_o | output | 2 | Pulsed sense-driver enables |
| wake_stat_o | output | 6 | Reported wake sources |

## Verification
The checker watches several rules on every cycle. The configuration never holds both mode bits, and never holds timed mode together with a driver enable. The word stays frozen while the block is in a low-power mode. An interrupt only ever follows Stop, and a reset request only ever follows Sleep. Driver pulses appear only in cyclic-sense mode, and the status word is clear right after entry. Other behaviours can only be shown by the bench's scenarios: which switch causes a wake once enables and multiplexer masking are applied, the exact tick on which each period ends, silence when a cyclic period sees no change, and the mode reached after a chip-select or reset-pin wake.

// File: rtl/lp_wake_pkg.sv
package lp_wake_pkg;
  localparam int unsigned N_SW   = 4;
  localparam int unsigned N_HS   = 2;
  localparam int unsigned SEL_W  = $clog2(N_SW);
  localparam int unsigned ST_LIN = N_SW;
  localparam int unsigned ST_TMR = N_SW + 1;
  localparam int unsigned ST_W   = N_SW + 2;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_NREQ   = 2'd1,
    MODE_STOP   = 2'd2,
    MODE_SLEEP  = 2'd3
  } lp_mode_e;

  typedef struct packed {
    logic [1:0]      per_sel;
    logic            frc_en;
    logic            cyc_en;
    logic [N_HS-1:0] hs_en;
    logic [N_SW-1:0] wen;
  } lp_cfg_t;

  localparam int unsigned CFG_W = $bits(lp_cfg_t);
endpackage

// File: rtl/lp_wake_cfg.sv
module lp_wake_cfg
  import lp_wake_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    we_i,
  input  logic    allow_i,
  input  lp_cfg_t wdata_i,
  output lp_cfg_t cfg_o
);
  logic legal;
  lp_cfg_t cfg_q;

  // modes exclusive; timed wake needs all drivers off
  assign legal = !(wdata_i.cyc_en && wdata_i.frc_en) &&
                 !(wdata_i.frc_en && (|wdata_i.hs_en));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (we_i && allow_i && legal) cfg_q <= wdata_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/lp_wake_timer.sv
module lp_wake_timer #(
  parameter int unsigned PER_0 = 4,
  parameter int unsigned PER_1 = 8,
  parameter int unsigned PER_2 = 16,
  parameter int unsigned PER_3 = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  output logic       last_o,
  output logic       end_o
);
  localparam int unsigned PMAX01 = (PER_0 > PER_1) ? PER_0 : PER_1;
  localparam int unsigned PMAX23 = (PER_2 > PER_3) ? PER_2 : PER_3;
  localparam int unsigned PMAX   = (PMAX01 > PMAX23) ? PMAX01 : PMAX23;
  localparam int unsigned CW     = (PMAX > 2) ? $clog2(PMAX) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] term;

  always_comb begin
    unique case (sel_i)
      2'd0:    term = CW'(PER_0 - 1);
      2'd1:    term = CW'(PER_1 - 1);
      2'd2:    term = CW'(PER_2 - 1);
      default: term = CW'(PER_3 - 1);
    endcase
  end

  assign last_o = run_i && (cnt_q == term);
  assign end_o  = last_o && tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || end_o)     cnt_q <= '0;
    else if (run_i && tick_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lp_wake_detect.sv
module lp_wake_detect
  import lp_wake_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             active_i,
  input  logic             sample_i,
  input  logic [N_SW-1:0]  sw_i,
  input  logic [N_SW-1:0]  wen_i,
  input  logic             mux_en_i,
  input  logic [SEL_W-1:0] mux_sel_i,
  output logic [N_SW-1:0]  chg_o
);
  logic [N_SW-1:0] ref_q;
  logic [N_SW-1:0] mask_q;

  for (genvar i = 0; i < N_SW; i++) begin : g_sw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ref_q[i]  <= 1'b0;
        mask_q[i] <= 1'b0;
      end else if (arm_i) begin
        ref_q[i]  <= sw_i[i];
        mask_q[i] <= wen_i[i] && !(mux_en_i && (mux_sel_i == SEL_W'(i)));
      end
    end
    assign chg_o[i] = active_i && sample_i && mask_q[i] && (sw_i[i] != ref_q[i]);
  end
endmodule

// File: rtl/lp_wake_seq.sv
module lp_wake_seq
  import lp_wake_pkg::*;
#(
  parameter int unsigned PER_0 = 4,
  parameter int unsigned PER_1 = 8,
  parameter int unsigned PER_2 = 16,
  parameter int unsigned PER_3 = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic             enter_stop_i,
  input  logic             enter_sleep_i,
  input  logic             nreq_sel_i,
  input  logic             lp_tick_i,
  input  logic [N_SW-1:0]  sw_i,
  input  logic             amux_en_i,
  input  logic [SEL_W-1:0] amux_sel_i,
  input  logic             cs_i,
  input  logic             lin_wake_i,
  input  logic             rst_pin_i,
  output logic [1:0]       mode_o,
  output logic             irq_o,
  output logic             reg_on_rst_o,
  output logic [N_HS-1:0]  hs_en_o,
  output logic [ST_W-1:0]  wake_stat_o
);
  lp_mode_e        mode_q;
  lp_cfg_t         cfg;
  logic            in_lp, in_stop, in_sleep, entering;
  logic            tmr_run, tmr_last, tmr_end;
  logic            sw_sample;
  logic [N_SW-1:0] sw_chg;
  logic            cs_q, cs_wake, rst_wake, lin_wake, tmr_wake;
  logic [ST_W-1:0] rep;
  logic            any_rep, wake;
  logic [ST_W-1:0] stat_q;
  logic            irq_q, rreq_q;

  assign in_stop  = (mode_q == MODE_STOP);
  assign in_sleep = (mode_q == MODE_SLEEP);
  assign in_lp    = in_stop || in_sleep;
  assign entering = !in_lp && (enter_stop_i || enter_sleep_i);

  lp_wake_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .allow_i (!in_lp),
    .wdata_i (lp_cfg_t'(cfg_wdata_i)),
    .cfg_o   (cfg)
  );

  assign tmr_run = in_lp && (cfg.cyc_en || cfg.frc_en);

  lp_wake_timer #(
    .PER_0 (PER_0),
    .PER_1 (PER_1),
    .PER_2 (PER_2),
    .PER_3 (PER_3)
  ) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (entering),
    .run_i  (tmr_run),
    .tick_i (lp_tick_i),
    .sel_i  (cfg.per_sel),
    .last_o (tmr_last),
    .end_o  (tmr_end)
  );

  // cyclic sense compares only at period end; otherwise continuously
  assign sw_sample = cfg.cyc_en ? tmr_end : 1'b1;

  lp_wake_detect u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (entering),
    .active_i  (in_lp),
    .sample_i  (sw_sample),
    .sw_i      (sw_i),
    .wen_i     (cfg.wen),
    .mux_en_i  (amux_en_i),
    .mux_sel_i (amux_sel_i),
    .chg_o     (sw_chg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= 1'b0;
    else         cs_q <= cs_i;
  end

  assign tmr_wake = tmr_end && cfg.frc_en;
  assign lin_wake = in_lp && lin_wake_i;
  assign cs_wake  = in_stop && cs_i && !cs_q;
  assign rst_wake = in_stop && rst_pin_i;
  assign rep      = {tmr_wake, lin_wake, sw_chg};
  assign any_rep  = |rep;
  assign wake     = any_rep || cs_wake || rst_wake;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_NORMAL;
      stat_q <= '0;
      irq_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      irq_q  <= 1'b0;
      rreq_q <= 1'b0;
      if (entering) begin
        mode_q <= enter_sleep_i ? MODE_SLEEP : MODE_STOP;
        stat_q <= '0;
      end else if (in_lp && wake) begin
        stat_q <= stat_q | rep;
        if (in_stop) begin
          irq_q  <= any_rep;
          mode_q <= (rst_wake && nreq_sel_i) ? MODE_NREQ : MODE_NORMAL;
        end else begin
          rreq_q <= 1'b1;
          mode_q <= MODE_NORMAL;
        end
      end
    end
  end

  assign hs_en_o      = (in_lp && cfg.cyc_en && tmr_last) ? cfg.hs_en : '0;
  assign cfg_rdata_o  = cfg;
  assign mode_o       = mode_q;
  assign irq_o        = irq_q;
  assign reg_on_rst_o = rreq_q;
  assign wake_stat_o  = stat_q;
endmodule

// File: rtl/lp_wake_seq_chk.sv
module lp_wake_seq_chk
  import lp_wake_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CFG_W-1:0] cfg_rdata_o,
  input logic [1:0]       mode_o,
  input logic             irq_o,
  input logic             reg_on_rst_o,
  input logic [N_HS-1:0]  hs_en_o,
  input logic [ST_W-1:0]  wake_stat_o
);
  lp_cfg_t c;
  assign c = lp_cfg_t'(cfg_rdata_o);

  assert_modes_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(c.cyc_en && c.frc_en));

  assert_frc_no_hs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c.frc_en |-> (c.hs_en == '0));

  assert_cfg_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[1] && $past(mode_o[1])) |-> $stable(cfg_rdata_o));

  assert_stat_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[1] && !$past(mode_o[1])) |-> (wake_stat_o == '0));

  assert_irq_after_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(mode_o) == MODE_STOP) && !mode_o[1]);

  assert_irq_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_rst_after_sleep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_on_rst_o |-> ($past(mode_o) == MODE_SLEEP) && !irq_o);

  assert_hs_only_cyclic_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_en_o != '0) |-> (mode_o[1] && c.cyc_en));
endmodule

bind lp_wake_seq lp_wake_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_rdata_o  (cfg_rdata_o),
  .mode_o       (mode_o),
  .irq_o        (irq_o),
  .reg_on_rst_o (reg_on_rst_o),
  .hs_en_o      (hs_en_o),
  .wake_stat_o  (wake_stat_o)
);

// File: tb/lp_wake_seq_tb.sv
module lp_wake_seq_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we = 1'b0;
  logic [9:0] cfg_wdata = '0;
  logic [9:0] cfg_rdata;
  logic       enter_stop = 1'b0, enter_sleep = 1'b0, nreq_sel = 1'b0;
  logic       lp_tick = 1'b0;
  logic [3:0] sw = '0;
  logic       amux_en = 1'b0;
  logic [1:0] amux_sel = '0;
  logic       cs = 1'b0, lin = 1'b0, rst_pin = 1'b0;
  logic [1:0] mode;
  logic       irq, rreq;
  logic [1:0] hs;
  logic [5:0] stat;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  lp_wake_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .enter_stop_i(enter_stop), .enter_sleep_i(enter_sleep),
    .nreq_sel_i(nreq_sel), .lp_tick_i(lp_tick), .sw_i(sw), .amux_en_i(amux_en),
    .amux_sel_i(amux_sel), .cs_i(cs), .lin_wake_i(lin), .rst_pin_i(rst_pin),
    .mode_o(mode), .irq_o(irq), .reg_on_rst_o(rreq), .hs_en_o(hs), .wake_stat_o(stat)
  );

  // {wen, mux_en, mux_sel, sleep, toggle, exp_wake, exp_sw}
  localparam logic [16:0] VEC [8] = '{
    {4'hF, 1'b0, 2'd0, 1'b0, 4'b0001, 1'b1, 4'b0001},
    {4'h5, 1'b0, 2'd0, 1'b0, 4'b0010, 1'b0, 4'b0000},
    {4'hF, 1'b1, 2'd2, 1'b0, 4'b0100, 1'b0, 4'b0000},
    {4'hF, 1'b1, 2'd2, 1'b0, 4'b0110, 1'b1, 4'b0010},
    {4'h8, 1'b0, 2'd0, 1'b1, 4'b1000, 1'b1, 4'b1000},
    {4'hF, 1'b0, 2'd0, 1'b1, 4'b1001, 1'b1, 4'b1001},
    {4'h0, 1'b0, 2'd0, 1'b0, 4'b1111, 1'b0, 4'b0000},
    {4'h3, 1'b1, 2'd0, 1'b1, 4'b0011, 1'b1, 4'b0010}
  };

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] mk(input logic [1:0] per, input logic frc, input logic cy,
                                    input logic [1:0] h, input logic [3:0] w);
    return {per, frc, cy, h, w};
  endfunction

  task automatic wr(input logic [9:0] v);
    cfg_we = 1'b1; cfg_wdata = v; cyc(); cfg_we = 1'b0;
  endtask

  task automatic enter(input logic slp);
    if (slp) enter_sleep = 1'b1; else enter_stop = 1'b1;
    cyc();
    enter_sleep = 1'b0; enter_stop = 1'b0;
  endtask

  task automatic lin_pulse();
    lin = 1'b1; cyc(); lin = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      lp_tick = 1'b1; cyc(); lp_tick = 1'b0;
      if (k != n - 1) cyc();
    end
  endtask

  initial begin
    repeat (3) cyc();
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 cfg", cfg_rdata, 0);
    chk("R1 outs", {stat, irq, rreq, hs}, 0);
    rst_ni = 1'b1;
    cyc();
    chk("R1 after release", {mode, cfg_rdata, stat, irq, rreq, hs}, 0);

    // table walk: R6 R7 R9 R10
    for (int v = 0; v < 8; v++) begin
      logic [3:0] wen, tog, esw;
      logic       men, slp, ew;
      logic [1:0] msel;
      {wen, men, msel, slp, tog, ew, esw} = VEC[v];
      wr(mk(2'd0, 1'b0, 1'b0, 2'b00, wen));
      amux_en = men; amux_sel = msel;
      enter(slp);
      amux_en = 1'b0;
      chk("R5 entered", mode, slp ? 3 : 2);
      cyc();
      sw = sw ^ tog;
      cyc();
      if (ew) begin
        chk("R6 R7 status", stat, {2'b00, esw});
        chk(slp ? "R10 reg_on_rst" : "R9 irq", {irq, rreq}, slp ? 2'b01 : 2'b10);
        chk("R9 R10 mode", mode, 0);
        cyc();
        chk("R9 R10 pulse one cycle", {irq, rreq}, 0);
      end else begin
        chk("R6 R7 no wake mode", mode, slp ? 3 : 2);
        chk("R6 R7 no wake quiet", {stat, irq, rreq}, 0);
        lin_pulse();
        chk("R8 lin status", stat, 6'h10);
        chk("R8 lin exit", {mode, irq}, {2'd0, 1'b1});
      end
    end

    // R2 write and readback
    wr(mk(2'd2, 1'b0, 1'b1, 2'b10, 4'b0110));
    chk("R2 readback", cfg_rdata, mk(2'd2, 1'b0, 1'b1, 2'b10, 4'b0110));
    // R3 rejected writes
    wr(mk(2'd1, 1'b1, 1'b1, 2'b00, 4'b0001));
    chk("R3 both modes rejected", cfg_rdata, mk(2'd2, 1'b0, 1'b1, 2'b10, 4'b0110));
    wr(mk(2'd1, 1'b1, 1'b0, 2'b01, 4'b0001));
    chk("R3 timed with driver rejected", cfg_rdata, mk(2'd2, 1'b0, 1'b1, 2'b10, 4'b0110));
    wr(mk(2'd1, 1'b1, 1'b0, 2'b00, 4'b0000));
    chk("R3 legal timed accepted", cfg_rdata, mk(2'd1, 1'b1, 1'b0, 2'b00, 4'b0000));

    // R11 timed wake, period 8, Stop; R4 write ignored in low power
    enter(1'b0);
    wr(mk(2'd0, 1'b0, 1'b0, 2'b00, 4'hF));
    chk("R4 write ignored", cfg_rdata, mk(2'd1, 1'b1, 1'b0, 2'b00, 4'b0000));
    ticks(7);
    chk("R11 before period end", {mode, irq, hs}, {2'd2, 1'b0, 2'b00});
    cyc();
    ticks(1);
    chk("R11 timed wake status", stat, 6'h20);
    chk("R11 timed wake irq", {mode, irq}, {2'd0, 1'b1});

    // R11 period 16 in Sleep
    wr(mk(2'd2, 1'b1, 1'b0, 2'b00, 4'b0000));
    enter(1'b1);
    ticks(15);
    chk("R11 sleep before end", {mode, rreq}, {2'd3, 1'b0});
    cyc();
    ticks(1);
    chk("R11 R10 sleep timed wake", {mode, rreq, irq, stat}, {2'd0, 1'b1, 1'b0, 6'h20});

    // R12 cyclic sense, period 4
    wr(mk(2'd0, 1'b0, 1'b1, 2'b01, 4'b0001));
    enter(1'b0);
    sw[0] = ~sw[0];
    cyc(); cyc();
    chk("R12 no direct wake", {mode, stat}, {2'd2, 6'h00});
    ticks(3);
    cyc();
    chk("R12 driver pulse", hs, 2'b01);
    ticks(1);
    chk("R12 period-end wake", {mode, irq, stat}, {2'd0, 1'b1, 6'h01});
    // period with no change
    enter(1'b0);
    ticks(4);
    cyc();
    chk("R12 no change stays", {mode, irq, hs}, {2'd2, 1'b0, 2'b00});
    lin_pulse();
    chk("R8 lin after cyclic", {mode, stat}, {2'd0, 6'h10});

    // R5 sleep wins when both requested; status cleared on entry
    wr(mk(2'd0, 1'b0, 1'b0, 2'b00, 4'b0000));
    enter_stop = 1'b1; enter_sleep = 1'b1; cyc();
    enter_stop = 1'b0; enter_sleep = 1'b0;
    chk("R5 sleep priority", mode, 3);
    chk("R5 status cleared", stat, 0);

    // R13 cs ignored in sleep
    cs = 1'b1; cyc(); cyc();
    chk("R13 cs ignored in sleep", {mode, rreq}, {2'd3, 1'b0});
    // R14 rst pin ignored in sleep
    rst_pin = 1'b1; cyc(); rst_pin = 1'b0; cyc();
    chk("R14 rst pin ignored in sleep", {mode, rreq}, {2'd3, 1'b0});
    lin_pulse();
    chk("R10 lin sleep exit", {mode, rreq, irq}, {2'd0, 1'b1, 1'b0});

    // R13 cs rising edge in Stop
    cs = 1'b0; cyc();
    enter(1'b0);
    cs = 1'b1; cyc();
    chk("R13 cs wake silent", {mode, irq, stat}, {2'd0, 1'b0, 6'h00});
    cs = 1'b0;

    // R14 rst pin wake into Normal-Request, then Normal
    nreq_sel = 1'b1;
    enter(1'b0);
    rst_pin = 1'b1; cyc(); rst_pin = 1'b0;
    chk("R14 to normal-request", {mode, irq, stat}, {2'd1, 1'b0, 6'h00});
    nreq_sel = 1'b0;
    enter(1'b0);
    chk("R5 entry from normal-request", mode, 2);
    rst_pin = 1'b1; cyc(); rst_pin = 1'b0;
    chk("R14 to normal", {mode, irq}, {2'd0, 1'b0});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule